// File: doc/BRIEF.md
# Grouped-Op Reorder Retire Unit

This block is the in-order tracking ring of an out-of-order core. Work arrives as control groups, each bundling one to three micro-operations. Up to two groups are allocated per cycle at the tail of a circular buffer. The dispatcher receives the entry index of each group it places, and it tags every micro-operation of that group with this index. Execution units then report finished micro-operations on two completion ports. Each report lowers the owning entry's outstanding count, and a report may carry an exception mark that sticks to the entry.

Groups leave from the head of the buffer strictly oldest first, up to two per cycle, and only once none of their micro-operations is still in flight. If the oldest group has finished but holds an exception, it does not retire. The block raises a one-cycle flush carrying that group's index, discards every tracked group, and restarts both pointers at entry zero. The head and tail pointers each carry one extra wrap bit, which separates a full ring from an empty one.

Top module: `grp_retire_buf`

## Requirements
- R1: With the default depth of 64, an empty buffer accepts exactly 64 single-group dispatches before `disp_ready` falls, and occupancy never exceeds the depth.
- R2: `disp_ready` is high only when the free entries cover the number of valid dispatch lanes (and no flush is shown). The accepted groups take consecutive entries from the tail: lane 0 first, then lane 1. `disp_idx0` equals the tail, and `disp_idx1` equals the tail plus 1 if lane 0 is valid, otherwise the tail. No entry is written while `disp_ready` is low.
- R3: Each entry stores a 2-bit outstanding count taken from dispatch, normally 1 to 3, where 0 means the group is already complete. Each completion report naming the entry lowers the count by one, so two reports in one cycle lower it by two. The count stops at zero.
- R4: Retire slot 0 fires only for the oldest tracked entry, and only when its count is zero and its exception flag is clear. A younger complete entry waits behind an incomplete older one.
- R5: Retire slot 1 fires only when slot 0 fires in the same cycle and the second-oldest entry is complete without exception, so at most two groups leave per cycle.
- R6: A completion report with its exception bit set marks the entry. The mark persists over later clean reports until the entry is freed.
- R7: When the oldest entry has count zero and its mark set, `flush_vld` is high with `flush_idx` equal to that entry, and neither retire slot fires. In the next cycle the buffer is empty and the next group is placed at entry 0.
- R8: In a flush cycle `disp_ready` is low, and completion reports are discarded.
- R9: All retire and flush outputs derive from registered state. An entry whose last completion is presented in cycle k is first shown retiring in cycle k+1.
- R10: A completion report naming an entry that holds no group has no effect, including on a group placed there later.
- R11: After reset the buffer is empty: `disp_ready` is high, no retire or flush is shown, and `disp_idx0` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_vld0 | input | 1 | Dispatch lane 0 carries a group |
| disp_cnt0 | input | 2 | Micro-op count of lane 0 group |
| disp_vld1 | input | 1 | Dispatch lane 1 carries a group |
| disp_cnt1 | input | 2 | Micro-op count of lane 1 group |
| disp_ready | output | 1 | Enough free entries; valid lanes are taken this cycle |
| disp_idx0 | output | 6 | Entry given to lane 0 |
| disp_idx1 | output | 6 | Entry given to lane 1 |
| cmp0_vld | input | 1 | Completion report on port 0 |
| cmp0_idx | input | 6 | Entry named by port 0 |
| cmp0_exc | input | 1 | Port 0 report carries an exception |
| cmp1_vld | input | 1 | Completion report on port 1 |
| cmp1_idx | input | 6 | Entry named by port 1 |
| cmp1_exc | input | 1 | Port 1 report carries an exception |
| ret0_vld | output | 1 | Oldest group retires this cycle |
| ret0_idx | output | 6 | Entry retiring in slot 0 |
| ret1_vld | output | 1 | Second-oldest group retires this cycle |
| ret1_idx | output | 6 | Entry retiring in slot 1 |
| flush_vld | output | 1 | Oldest group faulted; everything is discarded |
| flush_idx | output | 6 | Entry of the faulting group |

## Verification
`disp_ready` and the dispatch indices answer the dispatch inputs in the same cycle. Retire and flush outputs change one cycle after the completion edge that makes them true, and the pointers move at the edge that closes a retire or flush cycle. The bench drives each stimulus just after the falling edge. It reads the same-cycle answers one nanosecond later, before the rising edge. It reads the retire and flush results in the following low phase. It also reads the retire outputs in the cycle a completion is presented, to show they have not yet moved.

// File: rtl/grb_pkg.sv
`timescale 1ns/1ps
package grb_pkg;
  localparam int unsigned UOP_CNT_W = 2;
  typedef logic [UOP_CNT_W-1:0] uop_cnt_t;
endpackage

// File: rtl/grb_ptrs.sv
`timescale 1ns/1ps
// Head/tail pointers with wrap bit; occupancy derived from their difference.
module grb_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [1:0]      acc_num,
  input  logic [1:0]      ret_num,
  output logic [PTRW-1:0] head_q,
  output logic [PTRW-1:0] tail_q,
  output logic [PTRW-1:0] occ
);
  logic [PTRW-1:0] head_d, tail_d;
  logic            ptr_en;

  always_comb begin
    ptr_en = flush || (acc_num != 2'd0) || (ret_num != 2'd0);
    if (flush) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      head_d = head_q + PTRW'(ret_num);
      tail_d = tail_q + PTRW'(acc_num);
    end
    occ = tail_q - head_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end
endmodule

// File: rtl/grb_entry_array.sv
`timescale 1ns/1ps
// Per-entry state: valid, outstanding micro-op count, sticky exception mark.
module grb_entry_array
  import grb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc0_en,
  input  logic [IDXW-1:0]  alloc0_idx,
  input  uop_cnt_t         alloc0_cnt,
  input  logic             alloc1_en,
  input  logic [IDXW-1:0]  alloc1_idx,
  input  uop_cnt_t         alloc1_cnt,
  input  logic             rel0_en,
  input  logic [IDXW-1:0]  rel0_idx,
  input  logic             rel1_en,
  input  logic [IDXW-1:0]  rel1_idx,
  input  logic             c0_vld,
  input  logic [IDXW-1:0]  c0_idx,
  input  logic             c0_exc,
  input  logic             c1_vld,
  input  logic [IDXW-1:0]  c1_idx,
  input  logic             c1_exc,
  output logic [DEPTH-1:0] ent_vld,
  output logic [DEPTH-1:0] ent_done,
  output logic [DEPTH-1:0] ent_exc
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic     v_q, v_d, e_q, e_d, en;
    uop_cnt_t c_q, c_d;
    logic     hit0, hit1, a0, a1, rel;
    logic [1:0] dec;

    always_comb begin
      hit0 = c0_vld && (c0_idx == IDXW'(gi)) && v_q;
      hit1 = c1_vld && (c1_idx == IDXW'(gi)) && v_q;
      a0   = alloc0_en && (alloc0_idx == IDXW'(gi));
      a1   = alloc1_en && (alloc1_idx == IDXW'(gi));
      rel  = (rel0_en && (rel0_idx == IDXW'(gi))) ||
             (rel1_en && (rel1_idx == IDXW'(gi)));
      dec  = {1'b0, hit0} + {1'b0, hit1};
      v_d  = v_q;
      c_d  = c_q;
      e_d  = e_q;
      if (flush) begin
        v_d = 1'b0;
      end else if (a0) begin
        v_d = 1'b1;
        c_d = alloc0_cnt;
        e_d = 1'b0;
      end else if (a1) begin
        v_d = 1'b1;
        c_d = alloc1_cnt;
        e_d = 1'b0;
      end else if (rel) begin
        v_d = 1'b0;
      end else begin
        c_d = (c_q > dec) ? (c_q - dec) : '0;
        e_d = e_q || (hit0 && c0_exc) || (hit1 && c1_exc);
      end
      en = flush || a0 || a1 || rel || hit0 || hit1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
        e_q <= 1'b0;
      end else if (en) begin
        v_q <= v_d;
        c_q <= c_d;
        e_q <= e_d;
      end
    end

    assign ent_vld[gi]  = v_q;
    assign ent_done[gi] = (c_q == '0);
    assign ent_exc[gi]  = e_q;
  end
endmodule

// File: rtl/grb_retire_sel.sv
`timescale 1ns/1ps
// Picks the in-order retire pair at the head, or a flush on a faulted head.
module grb_retire_sel #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic [IDXW-1:0]  head_idx,
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [DEPTH-1:0] ent_done,
  input  logic [DEPTH-1:0] ent_exc,
  output logic             ret0,
  output logic [IDXW-1:0]  ret0_idx,
  output logic             ret1,
  output logic [IDXW-1:0]  ret1_idx,
  output logic             flush,
  output logic [IDXW-1:0]  flush_idx
);
  logic [IDXW-1:0] nxt_idx;
  logic            h_fin, n_fin;

  always_comb begin
    nxt_idx   = head_idx + IDXW'(1);
    h_fin     = ent_vld[head_idx] && ent_done[head_idx];
    n_fin     = ent_vld[nxt_idx]  && ent_done[nxt_idx];
    ret0      = h_fin && !ent_exc[head_idx];
    ret1      = ret0 && n_fin && !ent_exc[nxt_idx];
    flush     = h_fin && ent_exc[head_idx];
    ret0_idx  = head_idx;
    ret1_idx  = nxt_idx;
    flush_idx = head_idx;
  end
endmodule

// File: rtl/grp_retire_buf.sv
`timescale 1ns/1ps
module grp_retire_buf
  import grb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned PTRW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_vld0,
  input  logic [1:0]      disp_cnt0,
  input  logic            disp_vld1,
  input  logic [1:0]      disp_cnt1,
  output logic            disp_ready,
  output logic [IDXW-1:0] disp_idx0,
  output logic [IDXW-1:0] disp_idx1,
  input  logic            cmp0_vld,
  input  logic [IDXW-1:0] cmp0_idx,
  input  logic            cmp0_exc,
  input  logic            cmp1_vld,
  input  logic [IDXW-1:0] cmp1_idx,
  input  logic            cmp1_exc,
  output logic            ret0_vld,
  output logic [IDXW-1:0] ret0_idx,
  output logic            ret1_vld,
  output logic [IDXW-1:0] ret1_idx,
  output logic            flush_vld,
  output logic [IDXW-1:0] flush_idx
);
  logic [PTRW-1:0]  head_q, tail_q, occ, need, free_n;
  logic [DEPTH-1:0] ent_vld, ent_done, ent_exc;
  logic             acc0, acc1;
  logic [1:0]       acc_num, ret_num;

  always_comb begin
    need       = PTRW'(disp_vld0) + PTRW'(disp_vld1);
    free_n     = PTRW'(DEPTH) - occ;
    disp_ready = !flush_vld && (free_n >= need);
    acc0       = disp_vld0 && disp_ready;
    acc1       = disp_vld1 && disp_ready;
    disp_idx0  = tail_q[IDXW-1:0];
    disp_idx1  = tail_q[IDXW-1:0] + IDXW'(disp_vld0);
    acc_num    = {1'b0, acc0} + {1'b0, acc1};
    ret_num    = {1'b0, ret0_vld} + {1'b0, ret1_vld};
  end

  grb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush_vld),
    .acc_num (acc_num),
    .ret_num (ret_num),
    .head_q  (head_q),
    .tail_q  (tail_q),
    .occ     (occ)
  );

  grb_entry_array #(.DEPTH(DEPTH)) u_ents (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_vld),
    .alloc0_en  (acc0),
    .alloc0_idx (disp_idx0),
    .alloc0_cnt (uop_cnt_t'(disp_cnt0)),
    .alloc1_en  (acc1),
    .alloc1_idx (disp_idx1),
    .alloc1_cnt (uop_cnt_t'(disp_cnt1)),
    .rel0_en    (ret0_vld),
    .rel0_idx   (ret0_idx),
    .rel1_en    (ret1_vld),
    .rel1_idx   (ret1_idx),
    .c0_vld     (cmp0_vld),
    .c0_idx     (cmp0_idx),
    .c0_exc     (cmp0_exc),
    .c1_vld     (cmp1_vld),
    .c1_idx     (cmp1_idx),
    .c1_exc     (cmp1_exc),
    .ent_vld    (ent_vld),
    .ent_done   (ent_done),
    .ent_exc    (ent_exc)
  );

  grb_retire_sel #(.DEPTH(DEPTH)) u_sel (
    .head_idx  (head_q[IDXW-1:0]),
    .ent_vld   (ent_vld),
    .ent_done  (ent_done),
    .ent_exc   (ent_exc),
    .ret0      (ret0_vld),
    .ret0_idx  (ret0_idx),
    .ret1      (ret1_vld),
    .ret1_idx  (ret1_idx),
    .flush     (flush_vld),
    .flush_idx (flush_idx)
  );
endmodule

// File: rtl/grb_retire_chk.sv
`timescale 1ns/1ps
module grb_retire_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned PTRW = IDXW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            disp_vld0,
  input logic            disp_vld1,
  input logic            disp_ready,
  input logic            ret0_vld,
  input logic            ret1_vld,
  input logic            flush_vld,
  input logic [PTRW-1:0] head_q,
  input logic [PTRW-1:0] tail_q,
  input logic [PTRW-1:0] occ
);
  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTRW'(DEPTH)); // R1

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ == PTRW'(DEPTH)) && (disp_vld0 || disp_vld1)) |-> !disp_ready); // R2

  AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_ready && !flush_vld) |=> (tail_q == $past(tail_q))); // R2

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret0_vld && !ret1_vld) |=> (head_q == $past(head_q) + PTRW'(1))); // R4

  AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    ret1_vld |-> ret0_vld); // R5

  AST_FLUSH_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |-> !ret0_vld); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |=> ((occ == '0) && (tail_q == '0))); // R7
endmodule

bind grp_retire_buf grb_retire_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_vld0  (disp_vld0),
  .disp_vld1  (disp_vld1),
  .disp_ready (disp_ready),
  .ret0_vld   (ret0_vld),
  .ret1_vld   (ret1_vld),
  .flush_vld  (flush_vld),
  .head_q     (head_q),
  .tail_q     (tail_q),
  .occ        (occ)
);

// File: tb/sim_grp_retire_buf.sv
`timescale 1ns/1ps
module sim_grp_retire_buf;
  logic       clk, rst_n;
  logic       disp_vld0, disp_vld1;
  logic [1:0] disp_cnt0, disp_cnt1;
  logic       disp_ready;
  logic [5:0] disp_idx0, disp_idx1;
  logic       cmp0_vld, cmp0_exc, cmp1_vld, cmp1_exc;
  logic [5:0] cmp0_idx, cmp1_idx;
  logic       ret0_vld, ret1_vld, flush_vld;
  logic [5:0] ret0_idx, ret1_idx, flush_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  grp_retire_buf u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_vld0 = 0; disp_vld1 = 0; disp_cnt0 = 0; disp_cnt1 = 0;
    cmp0_vld = 0; cmp0_idx = 0; cmp0_exc = 0;
    cmp1_vld = 0; cmp1_idx = 0; cmp1_exc = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic c0(input int idx, input bit exc);
    cmp0_vld = 1; cmp0_idx = 6'(idx); cmp0_exc = exc;
  endtask

  task automatic c1(input int idx, input bit exc);
    cmp1_vld = 1; cmp1_idx = 6'(idx); cmp1_exc = exc;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 ready", disp_ready, 1);
    chk("R11 ret0", ret0_vld, 0);
    chk("R11 flush", flush_vld, 0);
    chk("R11 idx0", disp_idx0, 0);
  endtask

  task automatic t_basic();
    disp_vld0 = 1; disp_cnt0 = 1; disp_vld1 = 1; disp_cnt1 = 2; #1;
    chk("R2 ready two lanes", disp_ready, 1);
    chk("R2 idx0", disp_idx0, 0);
    chk("R2 idx1", disp_idx1, 1);
    step(); #1;
    chk("R4 no retire while outstanding", ret0_vld, 0);
    c0(1, 0); c1(0, 0); #1;
    chk("R9 same cycle no retire", ret0_vld, 0);
    step(); #1;
    chk("R9 retire next cycle", ret0_vld, 1);
    chk("R4 ret0 idx", ret0_idx, 0);
    chk("R5 slot1 waits on count", ret1_vld, 0);
    step(); c0(1, 0); #1;
    chk("R3 one of two done", ret0_vld, 0);
    step(); #1;
    chk("R3 second done retires", ret0_vld, 1);
    chk("R4 ret0 idx second", ret0_idx, 1);
    step();
  endtask

  task automatic t_order();
    disp_vld0 = 1; disp_cnt0 = 1; disp_vld1 = 1; disp_cnt1 = 1;
    step(); c0(3, 0);
    step(); #1;
    chk("R4 younger waits", ret0_vld, 0);
    c0(2, 0);
    step(); #1;
    chk("R5 ret0", ret0_vld, 1);
    chk("R5 ret1", ret1_vld, 1);
    chk("R5 ret0 idx", ret0_idx, 2);
    chk("R5 ret1 idx", ret1_idx, 3);
    step(); #1;
    chk("R4 empty after pair", ret0_vld, 0);
  endtask

  task automatic t_count();
    c0(5, 0);
    step();
    disp_vld0 = 1; disp_cnt0 = 3; disp_vld1 = 1; disp_cnt1 = 1; #1;
    chk("R2 idx1 placement", disp_idx1, 5);
    step(); c0(4, 0); c1(4, 0);
    step(); #1;
    chk("R3 dual report leaves one", ret0_vld, 0);
    c0(4, 0);
    step(); #1;
    chk("R3 third report retires", ret0_vld, 1);
    chk("R3 idx", ret0_idx, 4);
    chk("R10 stray report ignored", ret1_vld, 0);
    step(); c0(5, 0);
    step(); #1;
    chk("R10 entry retires on own report", ret0_idx, 5);
    step();
    disp_vld1 = 1; disp_cnt1 = 0; #1;
    chk("R2 lane1 alone at tail", disp_idx1, 6);
    step(); #1;
    chk("R3 zero count retires", ret0_vld, 1);
    chk("R3 zero count idx", ret0_idx, 6);
    step();
  endtask

  task automatic t_full();
    int n = 0;
    int rc = 0;
    for (int k = 0; k < 70; k++) begin
      disp_vld0 = 1; disp_cnt0 = 1; #1;
      if (!disp_ready) break;
      n++;
      step();
    end
    chk("R1 accepted count", n, 64);
    disp_vld1 = 1; disp_cnt1 = 1; #1;
    chk("R2 full stalls", disp_ready, 0);
    idle(); c0(7, 0);
    step(); #1;
    chk("R4 head after wrap", ret0_idx, 7);
    step();
    disp_vld0 = 1; disp_cnt0 = 1; disp_vld1 = 1; disp_cnt1 = 1; #1;
    chk("R2 one free two asked", disp_ready, 0);
    disp_vld1 = 0; #1;
    chk("R2 one free one asked", disp_ready, 1);
    idle();
    for (int j = 0; j < 63; j += 2) begin
      c0((8 + j) % 64, 0);
      if (j + 1 < 63) c1((9 + j) % 64, 0);
      #1;
      rc += int'(ret0_vld) + int'(ret1_vld);
      step();
    end
    for (int j = 0; j < 6; j++) begin
      #1;
      rc += int'(ret0_vld) + int'(ret1_vld);
      step();
    end
    chk("R5 drained count", rc, 63);
  endtask

  task automatic t_flush();
    disp_vld0 = 1; disp_cnt0 = 2; disp_vld1 = 1; disp_cnt1 = 1; #1;
    chk("R2 tail after drain", disp_idx0, 7);
    step();
    disp_vld0 = 1; disp_cnt0 = 1;
    step(); c0(7, 1); c1(8, 0);
    step(); #1;
    chk("R6 no flush while outstanding", flush_vld, 0);
    c0(7, 0);
    step();
    disp_vld0 = 1; disp_cnt0 = 1; c0(9, 0); #1;
    chk("R6 sticky mark flushes", flush_vld, 1);
    chk("R7 flush idx", flush_idx, 7);
    chk("R7 no retire on flush", ret0_vld, 0);
    chk("R8 ready low on flush", disp_ready, 0);
    step(); #1;
    chk("R7 restart at zero", disp_idx0, 0);
    chk("R7 flush one cycle", flush_vld, 0);
    chk("R7 emptied", ret0_vld, 0);
    disp_vld0 = 1; disp_cnt0 = 1;
    step(); c0(0, 0);
    step(); #1;
    chk("R7 new group retires", ret0_vld, 1);
    chk("R7 new group idx", ret0_idx, 0);
    step();
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_count();
    t_full();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule